// File: doc/BRIEF.md
# Quad-Channel Serial-Loaded Converter Code Register

This block is the digital front end of a four-channel 12-bit converter. A host sends a serial stream over three wires: a serial clock, a data line and a frame/load select. While the select is low, each rising edge of the serial clock moves one data bit into a 48-bit shift register. When the select rises, the frame closes and all four 12-bit channel codes are copied from the shift register into holding registers at once. The holding registers drive the analog channels, which are outside this block.

The bit that falls off the far end of the shift register is driven on a serial output. Several devices can be cascaded by chaining serial output to serial data, with clock and select shared by all of them. An active-low clear input forces every channel code to zero. All four serial-side inputs are asynchronous to the block. Each one is passed through a two-flop synchroniser in the fast system clock domain, and edges are detected on the synchronised copies.

Top module: `qdac_serial_load`

## Requirements
- R1: While `selLoad` is low, each rising edge of `serClk` shifts the current `serData` value into the shift register.
- R2: A frame carries channel A first, then B, then C, then D, each code most significant bit first. On `chanCodes`, channel A occupies bits [11:0], B bits [23:12], C bits [35:24] and D bits [47:36].
- R3: If more than 48 bits are clocked in before a load, only the last 48 bits clocked in determine the channel codes.
- R4: While `selLoad` is high, `serClk` edges have no effect: the shift register and `serOut` keep their values.
- R5: A rising edge of `selLoad` updates all four channel codes in the same system cycle. At any other time the codes hold, including while a frame is being shifted in.
- R6: `serOut` carries the most recently pushed-out bit of the shift register. It changes only after a rising `serClk` edge, so a frame shifted in appears on `serOut` bit for bit, first bit first, during the next frame.
- R7: While `clrN` is low, all channel codes are zero, and a load in the same cycle is overridden. Clearing leaves the shift register unchanged, so a later load without new bits restores the codes that were shifted in before the clear.
- R8: After power-on reset, all channel codes are zero and `serOut` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial inputs |
| rstN | input | 1 | Active-low power-on reset |
| serClk | input | 1 | Serial clock, asynchronous |
| serData | input | 1 | Serial data, asynchronous |
| selLoad | input | 1 | Frame select: low enables shifting, a rising edge loads the channels |
| clrN | input | 1 | Active-low clear of all channel codes |
| serOut | output | 1 | Far end of the shift register, used for cascading |
| chanCodes | output | 48 | Four 12-bit channel codes, channel A in the low bits |

## Verification
The embedded properties check the following on every system cycle:
- a cleared cycle is followed by all-zero codes;
- codes move only on a load strobe, and a load copies the expected shift-register slices;
- the shift register stays frozen when no shift strobe arrives;
- `serOut` follows the bit that was just pushed out.

Only the bench scenarios can show the end-to-end serial behaviour through the synchronisers. These scenarios cover frame ordering across several code patterns, overlong frames keeping the last 48 bits, cascaded output reproducing the previous frame, clocks ignored while deselected, and restoring the shift register contents after a clear.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // Strobes handed from the control to the datapath, one system cycle wide
  typedef struct packed {
    logic shiftEn;   // move one serial bit into the shift register
    logic loadEn;    // copy all channel slices into the holding registers
    logic clearAll;  // force all holding registers to zero
  } qdac_strobe_t;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int unsigned             WIDTH   = 4,
  parameter int unsigned             STAGES  = 2,
  parameter logic [WIDTH-1:0]        RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  // Shift chain of flop rows; row 0 takes the raw inputs
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain <= {chain[STAGES-2:0], asyncIn};
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         clkSync,
  input  logic         selSync,
  input  logic         clrSync,
  output qdac_strobe_t strobe
);

  logic clkPrev;
  logic selPrev;
  logic clkRise;
  logic selRise;

  // Previous values for edge detection on the synchronised copies
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev <= 1'b0;
      selPrev <= 1'b1;
    end else begin
      clkPrev <= clkSync;
      selPrev <= selSync;
    end
  end

  assign clkRise = clkSync & ~clkPrev;
  assign selRise = selSync & ~selPrev;

  always_comb begin
    strobe          = '0;
    strobe.shiftEn  = clkRise & ~selSync;  // serial clock gated while deselected
    strobe.loadEn   = selRise;
    strobe.clearAll = ~clrSync;
  end

  // R5: a load strobe lasts exactly one system cycle per select edge
  p_load_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> !strobe.loadEn);

  // R4: no shift strobe follows a cycle in which the select was high and stays high
  p_no_shift_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (selSync && $past(selSync)) |-> !strobe.shiftEn);

endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
#(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned NUM_CH = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  qdac_strobe_t               strobe,
  input  logic                       dataSync,
  output logic                       serOut,
  output logic [NUM_CH*CODE_W-1:0]   chanCodes
);

  localparam int unsigned FRAME_W = NUM_CH * CODE_W;

  logic [FRAME_W-1:0] shiftReg;

  // Serial shift register: new bits enter at bit 0, first bit ends at the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.shiftEn) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], dataSync};
    end
  end

  assign serOut = shiftReg[FRAME_W-1];

  // Holding registers; channel 0 (first sent) is the top slice of the frame
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CODE_W-1:0] codeQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        codeQ <= '0;
      end else if (strobe.clearAll) begin
        codeQ <= '0;
      end else if (strobe.loadEn) begin
        codeQ <= shiftReg[FRAME_W-1-ch*CODE_W -: CODE_W];
      end
    end

    assign chanCodes[ch*CODE_W +: CODE_W] = codeQ;
  end

  // R7: a clear cycle leaves every code at zero
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |=> (chanCodes == '0));

  // R5: codes move only when a load or clear strobe was present
  p_codes_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadEn && !strobe.clearAll) |=> $stable(chanCodes));

  // R2: first channel takes the oldest bits, last channel the newest
  p_load_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadEn && !strobe.clearAll) |=>
      (chanCodes[CODE_W-1:0] == $past(shiftReg[FRAME_W-1 -: CODE_W])) &&
      (chanCodes[FRAME_W-1 -: CODE_W] == $past(shiftReg[CODE_W-1:0])));

  // R4: without a shift strobe the register does not move
  p_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(shiftReg));

  // R6: the output shows the bit that was one below the top before the shift
  p_dout_shift_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> (serOut == $past(shiftReg[FRAME_W-2])));

  // R8: outputs leave reset at zero
  p_reset_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (chanCodes == '0 && serOut == 1'b0));

endmodule

// File: rtl/qdac_serial_load.sv
module qdac_serial_load
  import qdac_pkg::*;
#(
  parameter int unsigned CODE_W      = 12,
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     serClk,
  input  logic                     serData,
  input  logic                     selLoad,
  input  logic                     clrN,
  output logic                     serOut,
  output logic [NUM_CH*CODE_W-1:0] chanCodes
);

  localparam int unsigned       N_IN     = 4;
  localparam logic [N_IN-1:0]   IN_RESET = 4'b1100;  // {clr, sel, data, clk}

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] syncIn;
  qdac_strobe_t    strobe;

  assign rawIn = {clrN, selLoad, serData, serClk};

  qdac_sync #(
    .WIDTH   (N_IN),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (IN_RESET)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawIn),
    .syncOut (syncIn)
  );

  qdac_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .clkSync (syncIn[0]),
    .selSync (syncIn[2]),
    .clrSync (syncIn[3]),
    .strobe  (strobe)
  );

  qdac_datapath #(
    .CODE_W (CODE_W),
    .NUM_CH (NUM_CH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .dataSync  (syncIn[1]),
    .serOut    (serOut),
    .chanCodes (chanCodes)
  );

endmodule

// File: tb/sim_qdac_serial_load.sv
module sim_qdac_serial_load;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        selLoad = 1'b1;
  logic        clrN = 1'b1;
  logic        serOut;
  logic [47:0] chanCodes;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  qdac_serial_load u0 (
    .clk       (clk),
    .rstN      (rstN),
    .serClk    (serClk),
    .serData   (serData),
    .selLoad   (selLoad),
    .clrN      (clrN),
    .serOut    (serOut),
    .chanCodes (chanCodes)
  );

  localparam int NVEC = 6;
  localparam logic [47:0] FRAMES [NVEC] = '{
    48'h123_456_789_ABC,
    48'hFFF_000_FFF_000,
    48'h000_FFF_000_FFF,
    48'hA5A_5A5_C3C_3C3,
    48'h800_001_7FE_001,
    48'hFFF_FFF_FFF_FFF
  };

  // Expected port image: channel A (first sent) in bits [11:0]
  function automatic logic [47:0] expCodes(input logic [47:0] f);
    logic [47:0] r;
    for (int k = 0; k < 4; k++) r[k*12 +: 12] = f[47-12*k -: 12];
    return r;
  endfunction

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    serData = b;
    tick(4);
    serClk = 1'b1;
    tick(4);
    serClk = 1'b0;
    tick(4);
  endtask

  task automatic beginFrame();
    selLoad = 1'b0;
    tick(4);
  endtask

  task automatic endFrame();
    selLoad = 1'b1;
    tick(6);
  endtask

  // Shift a frame, recording serOut before each serial edge
  task automatic sendFrame(input logic [47:0] f, output logic [47:0] seen);
    for (int i = 0; i < 48; i++) begin
      seen[47-i] = serOut;
      sendBit(f[47-i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [47:0] seen;
    logic [47:0] prev;

    tick(3);
    // R8: reset state
    chk("R8 codes after reset", chanCodes, 48'h0);
    chk("R8 serOut after reset", {47'h0, serOut}, 48'h0);
    rstN = 1'b1;
    tick(6);
    chk("R8 codes after release", chanCodes, 48'h0);

    // R1 R2 R6: table of frames, each checked on codes and cascaded output
    prev = 48'h0;
    for (int v = 0; v < NVEC; v++) begin
      beginFrame();
      sendFrame(FRAMES[v], seen);
      endFrame();
      chk("R1 R2 frame load", chanCodes, expCodes(FRAMES[v]));
      chk("R6 serOut replays previous frame", seen, prev);
      prev = FRAMES[v];
    end

    // R4: clocks while deselected change nothing
    beginFrame();
    sendFrame(48'h123_456_789_ABC, seen);
    endFrame();
    for (int i = 0; i < 10; i++) sendBit(1'b1);
    chk("R4 serOut frozen while deselected", {47'h0, serOut}, 48'h0);
    beginFrame();
    endFrame();
    chk("R4 reload after ignored clocks", chanCodes, expCodes(48'h123_456_789_ABC));

    // R5: codes hold mid-frame, then all update together
    beginFrame();
    for (int i = 0; i < 20; i++) sendBit(FRAMES[3][47-i]);
    chk("R5 codes hold mid-frame", chanCodes, expCodes(48'h123_456_789_ABC));
    for (int i = 20; i < 48; i++) sendBit(FRAMES[3][47-i]);
    chk("R5 codes hold before select edge", chanCodes, expCodes(48'h123_456_789_ABC));
    endFrame();
    chk("R5 all channels loaded", chanCodes, expCodes(FRAMES[3]));

    // R3: overlong frame keeps the last 48 bits
    beginFrame();
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b1);
    sendFrame(48'h5A5_0F0_123_FED, seen);
    endFrame();
    chk("R3 last 48 bits kept", chanCodes, expCodes(48'h5A5_0F0_123_FED));

    // R7: clear, override of load, shift register kept
    clrN = 1'b0;
    tick(6);
    chk("R7 clear forces zero", chanCodes, 48'h0);
    beginFrame();
    endFrame();
    chk("R7 clear overrides load", chanCodes, 48'h0);
    clrN = 1'b1;
    tick(6);
    chk("R7 zero held after clear release", chanCodes, 48'h0);
    chk("R7 serOut unchanged by clear", {47'h0, serOut}, 48'h0);
    beginFrame();
    endFrame();
    chk("R7 shift register kept through clear", chanCodes, expCodes(48'h5A5_0F0_123_FED));

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule